// File: doc/BRIEF.md
# UART FIFO Control and Status Unit

This unit sits between a UART's bit-level serializer/deserializer and the register bus. It keeps one byte FIFO for each direction and presents a control word, a packed status word, a line-status word, a sticky error word, a receive-data port and a transmit-data port on a small register interface. The depth of both FIFOs is a parameter.

Software turns the FIFOs on through the control word, sets a receive and a transmit trigger field, and can empty either FIFO with a reset bit that clears itself. With the FIFOs turned off, received bytes land in a single holding register, and the transmit side takes one byte at a time. Three registered event outputs feed an interrupt controller that sits outside this block: receive data ready, transmit occupancy at or below its trigger, and a one-cycle error pulse on any overflow or underflow.

Reads return data in `reg_rdata` on the cycle after `reg_rd` is sampled. A read of the receive-data or error register changes state at that same clock edge.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, the line-status word reads 0x2 (transmit side empty), the error word reads 0 and `tx_valid` is low.
- R2: The register addresses are: 0 = control, 1 = status, 2 = line status, 3 = error, 4 = receive data, 5 = transmit data. In the control word, bit 0 enables the FIFOs, bits [6:4] hold the receive trigger field and bits [10:8] hold the transmit trigger field. All three read back as written, and every other bit reads 0.
- R3: Writing control bit 1 empties the receive FIFO and the holding register. Writing control bit 2 empties the transmit FIFO. Both bits always read back as 0, and the rest of the written word still takes effect.
- R4: The status word carries the receive count in [7:0], receive-full in bit 8, receive-error in bit 9, the transmit count in [23:16] and transmit-full in bit 24. A count field reads 0 whenever its FIFO is completely full.
- R5: In FIFO mode, bytes read from the receive-data register come out in arrival order. Line-status bit 0 (data ready) stays 1 until a read empties the FIFO.
- R6: In FIFO mode, a read of the receive-data register while the FIFO is empty returns 0, sets error bit 1 and pulses `ev_error`.
- R7: A byte pushed into a full receive FIFO is dropped. The stored bytes are kept, error bit 0 is set and `ev_error` pulses. The count never exceeds the depth.
- R8: With the FIFOs disabled, a received byte overwrites a single holding register and sets data ready. A read returns that byte and clears data ready. A read with nothing held raises no error.
- R9: The error word (bit 0 receive overflow, bit 1 receive underflow, bit 2 transmit overflow) clears when it is read. Status bit 9 is set while bit 0 or bit 1 is set.
- R10: A write to the transmit-data register queues a byte. `tx_valid` and `tx_byte` present the oldest byte, and `tx_pop` removes it. A write into a full transmit FIFO, or a write in non-FIFO mode while a byte is waiting, is dropped and sets error bit 2.
- R11: `ev_rx_ready` is registered. In FIFO mode it is high when the receive count is nonzero and at least the receive trigger field times DEPTH/8. In non-FIFO mode it follows data ready.
- R12: `ev_tx_below` is registered. In FIFO mode it is high when the transmit count is at most the transmit trigger field times DEPTH/8. In non-FIFO mode it is high when the transmit side is empty.
- R13: `ev_error` is high for exactly the one cycle after each clock edge at which an overflow or underflow occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read |
| rx_push | input | 1 | Received byte strobe from the deserializer |
| rx_byte | input | DATA_W | Received byte |
| tx_valid | output | 1 | A transmit byte is waiting |
| tx_byte | output | DATA_W | Oldest transmit byte |
| tx_pop | input | 1 | Serializer takes the presented byte |
| ev_rx_ready | output | 1 | Receive data at or above trigger |
| ev_tx_below | output | 1 | Transmit occupancy at or below trigger |
| ev_error | output | 1 | One-cycle overflow/underflow pulse |

## Verification
The assertions watch several properties on every cycle. The reset bits must read back as 0. A full FIFO must report a zero count with the full bit set. An empty read in FIFO mode must return 0 together with an error pulse. The error word must clear after a read. Occupancy must never pass the depth, and each accepted pop must lower the transmit count by one. Some behaviours can only be shown by the bench's sweeps over every fill level and every trigger field of an eight-deep configuration: arrival order of the data, the exact threshold of both trigger events, byte loss on overflow with the stored contents intact, and the holding-register behaviour in non-FIFO mode.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_LINE = 3'd2,
    A_ERR  = 3'd3,
    A_RXD  = 3'd4,
    A_TXD  = 3'd5
  } reg_addr_e;

  localparam int C_EN    = 0;
  localparam int C_RXCLR = 1;
  localparam int C_TXCLR = 2;

  // Count field of the status word: zero while the FIFO is full.
  function automatic logic [7:0] count_field(input logic [15:0] cnt, input logic full);
    return full ? 8'h00 : cnt[7:0];
  endfunction
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_trig_scale.sv
module uart_trig_scale #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  localparam int STEP = DEPTH / 8
) (
  input  logic [2:0]       field,
  output logic [CNT_W-1:0] level
);
  generate
    if (STEP >= 1) begin : g_scaled
      assign level = CNT_W'(field) * CNT_W'(STEP);
    end else begin : g_shallow
      assign level = (field == 3'd0) ? '0 : CNT_W'(1);
    end
  endgenerate
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              tx_pop,
  output logic              ev_rx_ready,
  output logic              ev_tx_below,
  output logic              ev_error
);
  logic              fifo_en_q;
  logic [2:0]        rx_trig_q, tx_trig_q;
  logic [DATA_W-1:0] hold_q;
  logic              hold_vld_q;
  logic [2:0]        err_q;

  logic              wr_ctrl, rx_clr, tx_clr, rd_rxd, wr_txd, rd_err;
  logic              rx_ovf, rx_unf, tx_ovf, data_ready;
  logic              rx_empty, rx_full, tx_empty, tx_full;
  logic [CNT_W-1:0]  rx_count, tx_count, rx_level, tx_level;
  logic [DATA_W-1:0] rx_dout;
  logic [31:0]       rd_word;
  logic              unused_wdata;

  assign unused_wdata = ^{reg_wdata[31:11], reg_wdata[7], reg_wdata[3]};

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign rx_clr  = wr_ctrl && reg_wdata[C_RXCLR];
  assign tx_clr  = wr_ctrl && reg_wdata[C_TXCLR];
  assign rd_rxd  = reg_rd && (reg_addr == A_RXD);
  assign wr_txd  = reg_wr && (reg_addr == A_TXD);
  assign rd_err  = reg_rd && (reg_addr == A_ERR);

  assign rx_ovf = rx_push && fifo_en_q && rx_full;
  assign rx_unf = rd_rxd && fifo_en_q && rx_empty;
  assign tx_ovf = wr_txd && (fifo_en_q ? tx_full : !tx_empty);

  uart_byte_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_rx_fifo (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_push && fifo_en_q), .din(rx_byte),
    .pop(rd_rxd && fifo_en_q), .dout(rx_dout),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_tx_fifo (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(wr_txd && !tx_ovf), .din(reg_wdata[DATA_W-1:0]),
    .pop(tx_pop), .dout(tx_byte),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  uart_trig_scale #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_lvl (.field(rx_trig_q), .level(rx_level));
  uart_trig_scale #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_lvl (.field(tx_trig_q), .level(tx_level));

  assign tx_valid   = !tx_empty;
  assign data_ready = fifo_en_q ? !rx_empty : hold_vld_q;

  // Control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en_q <= 1'b0;
      rx_trig_q <= '0;
      tx_trig_q <= '0;
    end else if (wr_ctrl) begin
      fifo_en_q <= reg_wdata[C_EN];
      rx_trig_q <= reg_wdata[6:4];
      tx_trig_q <= reg_wdata[10:8];
    end
  end

  // Non-FIFO holding register; a new byte wins over a read in the same cycle
  always_ff @(posedge clk) begin
    if (rst || rx_clr) begin
      hold_vld_q <= 1'b0;
    end else if (rx_push && !fifo_en_q) begin
      hold_vld_q <= 1'b1;
    end else if (rd_rxd && !fifo_en_q) begin
      hold_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (rx_push && !fifo_en_q) hold_q <= rx_byte;
  end

  // Sticky error word, cleared by a read; new events in the read cycle survive
  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (rd_err ? 3'b000 : err_q) | {tx_ovf, rx_unf, rx_ovf};
  end

  always_comb begin
    rd_word = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_word[C_EN]  = fifo_en_q;
        rd_word[6:4]   = rx_trig_q;
        rd_word[10:8]  = tx_trig_q;
      end
      A_STAT: begin
        rd_word[7:0]   = count_field(16'(rx_count), rx_full);
        rd_word[8]     = rx_full;
        rd_word[9]     = err_q[0] | err_q[1];
        rd_word[23:16] = count_field(16'(tx_count), tx_full);
        rd_word[24]    = tx_full;
      end
      A_LINE: begin
        rd_word[0] = data_ready;
        rd_word[1] = tx_empty;
      end
      A_ERR:  rd_word[2:0] = err_q;
      A_RXD: begin
        if (fifo_en_q) rd_word[DATA_W-1:0] = rx_empty ? '0 : rx_dout;
        else           rd_word[DATA_W-1:0] = hold_q;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

  // Registered event outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_rx_ready <= 1'b0;
      ev_tx_below <= 1'b0;
      ev_error    <= 1'b0;
    end else begin
      ev_rx_ready <= fifo_en_q ? (!rx_empty && (rx_count >= rx_level)) : hold_vld_q;
      ev_tx_below <= fifo_en_q ? (tx_count <= tx_level) : tx_empty;
      ev_error    <= rx_ovf | rx_unf | tx_ovf;
    end
  end
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_rdata,
  input logic             rx_push,
  input logic             tx_pop,
  input logic             tx_valid,
  input logic             ev_error,
  input logic             fifo_en,
  input logic             rx_empty,
  input logic             rx_full,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [2:0]       err_bits
);
  assert_ctrl_selfclear_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_CTRL) |=> (reg_rdata[2:1] == 2'b00));

  assert_full_count_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_STAT && rx_full) |=> (reg_rdata[7:0] == 8'h00 && reg_rdata[8]));

  assert_underflow_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_RXD && fifo_en && rx_empty) |=> (reg_rdata == 32'h0 && ev_error));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt <= CNT_W'(DEPTH)) && (tx_cnt <= CNT_W'(DEPTH)));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_ERR && !rx_push && !reg_wr) |=> (err_bits == 3'b000));

  assert_tx_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && tx_valid && !reg_wr) |=> (tx_cnt == $past(tx_cnt) - CNT_W'(1)));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .rx_push(rx_push), .tx_pop(tx_pop), .tx_valid(tx_valid),
  .ev_error(ev_error), .fifo_en(fifo_en_q), .rx_empty(rx_empty), .rx_full(rx_full),
  .rx_cnt(rx_count), .tx_cnt(tx_count), .err_bits(err_q)
);

// File: tb/uart_fifo_ctrl_test.sv
module uart_fifo_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEP = 8;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_LINE = 3'd2,
                         AD_ERR = 3'd3, AD_RXD = 3'd4, AD_TXD = 3'd5;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, rx_push = 0, tx_pop = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] rx_byte = '0, tx_byte;
  logic tx_valid, ev_rx_ready, ev_tx_below, ev_error;

  int tests = 0, fails = 0;
  logic err_seen;
  logic [31:0] d;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_ctrl #(.DEPTH(DEP), .DATA_W(8)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_pop(tx_pop),
    .ev_rx_ready(ev_rx_ready), .ev_tx_below(ev_tx_below), .ev_error(ev_error)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 0; err_seen = ev_error;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; v = reg_rdata; err_seen = ev_error;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_byte = b;
    @(negedge clk); rx_push = 0; err_seen = ev_error;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    rd(AD_CTRL, d); chk("R1 ctrl", d, 0);
    rd(AD_STAT, d); chk("R1 stat", d, 0);
    rd(AD_LINE, d); chk("R1 line", d, 32'h2);
    rd(AD_ERR, d);  chk("R1 err", d, 0);

    // R2 control fields read back, unused bits read 0
    wr(AD_CTRL, 32'hFFFF_FFF9); rd(AD_CTRL, d); chk("R2 ctrl rb", d, 32'h771);
    wr(AD_CTRL, 32'h0000_0350); rd(AD_CTRL, d); chk("R2 ctrl rb2", d, 32'h350);

    // Receive sweep over every fill level and trigger field
    for (int k = 0; k <= DEP; k++) begin
      wr(AD_CTRL, 32'h7);
      for (int i = 0; i < k; i++) push(8'(k * 8 + i));
      rd(AD_STAT, d);
      chk("R4 rx count", {24'b0, d[7:0]}, (k == DEP) ? 0 : k);
      chk("R4 rx full", {31'b0, d[8]}, (k == DEP) ? 1 : 0);
      rd(AD_LINE, d); chk("R5 ready", {31'b0, d[0]}, (k != 0) ? 1 : 0);
      if (k == DEP) begin
        push(8'hEE); chk("R7 ovf pulse", {31'b0, err_seen}, 1);
        idle(1); chk("R13 one cycle", {31'b0, ev_error}, 0);
        rd(AD_STAT, d); chk("R9 stat err", {31'b0, d[9]}, 1);
        chk("R7 count kept", {23'b0, d[8:0]}, 32'h100);
        rd(AD_ERR, d); chk("R9 err ovf", d, 32'h1);
        rd(AD_ERR, d); chk("R9 err cleared", d, 0);
      end
      for (int f = 0; f < 8; f++) begin
        wr(AD_CTRL, 32'h1 | (f << 4)); idle(2);
        chk($sformatf("R11 rx_ready k=%0d f=%0d", k, f), {31'b0, ev_rx_ready},
            (k != 0 && k >= f) ? 1 : 0);
      end
      for (int i = 0; i < k; i++) begin
        rd(AD_RXD, d); chk("R5 order", d, 32'(8'(k * 8 + i)));
        rd(AD_LINE, d); chk("R5 ready hold", {31'b0, d[0]}, (i < k - 1) ? 1 : 0);
      end
      rd(AD_RXD, d); chk("R6 empty read", d, 0);
      chk("R6 err pulse", {31'b0, err_seen}, 1);
      rd(AD_ERR, d); chk("R6 err bit", d, 32'h2);
    end

    // Transmit sweep
    for (int k = 0; k <= DEP; k++) begin
      wr(AD_CTRL, 32'h5);
      for (int i = 0; i < k; i++) wr(AD_TXD, 32'(8'(8'hA0 + k * 8 + i)));
      chk("R10 tx_valid", {31'b0, tx_valid}, (k != 0) ? 1 : 0);
      rd(AD_STAT, d);
      chk("R4 tx count", {24'b0, d[23:16]}, (k == DEP) ? 0 : k);
      chk("R4 tx full", {31'b0, d[24]}, (k == DEP) ? 1 : 0);
      if (k == DEP) begin
        wr(AD_TXD, 32'h11); chk("R10 tx ovf pulse", {31'b0, err_seen}, 1);
        rd(AD_ERR, d); chk("R10 err bit", d, 32'h4);
      end
      for (int f = 0; f < 8; f++) begin
        wr(AD_CTRL, 32'h1 | (f << 8)); idle(2);
        chk($sformatf("R12 tx_below k=%0d f=%0d", k, f), {31'b0, ev_tx_below},
            (k <= f) ? 1 : 0);
      end
      for (int i = 0; i < k; i++) begin
        @(negedge clk);
        chk("R10 tx order", {24'b0, tx_byte}, 32'(8'(8'hA0 + k * 8 + i)));
        tx_pop = 1;
        @(negedge clk); tx_pop = 0;
      end
      chk("R10 drained", {31'b0, tx_valid}, 0);
    end

    // R3 partial clear keeps the other FIFO and applies the rest of the word
    wr(AD_CTRL, 32'h7);
    for (int i = 0; i < 3; i++) begin push(8'(i)); wr(AD_TXD, 32'(i)); end
    wr(AD_CTRL, 32'h253);
    rd(AD_CTRL, d); chk("R3 selfclear", d, 32'h251);
    rd(AD_STAT, d); chk("R3 rx cleared tx kept", d, 32'h0003_0000);
    wr(AD_CTRL, 32'h5);
    rd(AD_STAT, d); chk("R3 tx cleared", d, 0);

    // R8 non-FIFO holding register
    wr(AD_CTRL, 32'h2);
    push(8'h41); push(8'h42);
    rd(AD_LINE, d); chk("R8 ready set", {31'b0, d[0]}, 1);
    idle(1); chk("R11 nonfifo ready", {31'b0, ev_rx_ready}, 1);
    rd(AD_RXD, d); chk("R8 latest byte", d, 32'h42);
    rd(AD_LINE, d); chk("R8 ready cleared", {31'b0, d[0]}, 0);
    idle(1); chk("R11 nonfifo idle", {31'b0, ev_rx_ready}, 0);
    rd(AD_RXD, d); chk("R8 no error", {31'b0, err_seen}, 0);
    rd(AD_ERR, d); chk("R8 err clean", d, 0);

    // R10/R12 non-FIFO transmit
    wr(AD_CTRL, 32'h4); idle(1);
    chk("R12 nonfifo empty", {31'b0, ev_tx_below}, 1);
    wr(AD_TXD, 32'h55); idle(1);
    chk("R12 nonfifo busy", {31'b0, ev_tx_below}, 0);
    wr(AD_TXD, 32'h66); chk("R10 nonfifo drop pulse", {31'b0, err_seen}, 1);
    chk("R10 nonfifo byte", {24'b0, tx_byte}, 32'h55);
    @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;
    chk("R10 nonfifo popped", {31'b0, tx_valid}, 0);
    rd(AD_ERR, d); chk("R9 tx err", d, 32'h4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule